// File: doc/BRIEF.md
# Card command response receiver

This block listens on the command line of a memory card once a command has gone out, and captures the response the card sends back. After an arm pulse it waits for the first low start bit. It then shifts in either a short (48-bit) or a long (136-bit) response, one bit per clock. Each completed byte goes into a 17-entry receive store.

When the last bit arrives, the block checks the framing and, unless told not to, the CRC7. It then raises a sticky end-of-response flag, which serves as the interrupt request. Software reads the bytes back one at a time through a byte-wide port. Pulsing the pointer-reset input rewinds that port to the first byte. The three configuration inputs are latched at arm time:

- whether a response is expected at all,
- which response size to expect,
- whether to skip the CRC check.

Top module: `cmd_resp_rx`

## Requirements
- R1: A one-cycle `cmd_done_i` while idle with `resp_en_i` high makes `busy_o` high on the next cycle. The block then treats line value 1 as idle and ignores it. Reception begins with the first 0 on `cmd_line_i`, which counts as stream bit 0.
- R2: When `resp_en_i` is low at `cmd_done_i`, the block does not arm. `busy_o` and `eor_o` stay low, and later line activity captures nothing.
- R3: `resp_long_i`, latched at arm, selects the response length: 0 gives 48 bits and 1 gives 136 bits. The cycle after the last bit is sampled, `eor_o` is high and `busy_o` is low.
- R4: Stream bit 0 is the first bit on the line. Byte k is made of stream bits 8k..8k+7, with the first-received bit as its MSB, and is stored at index k. `rd_data_o` shows the entry at the read pointer. A cycle with `rd_en_i` high advances the pointer, which wraps from 16 back to 0.
- R5: While `rptr_rst_i` is high, the read pointer is held at 0. After `rptr_rst_i` is set and then cleared, `rd_data_o` shows byte 0.
- R6: The CRC7 uses polynomial x^7+x^3+1 with a zero seed. It covers stream bits 0..39 for a short response and bits 8..127 for a long one, and is compared with the next 7 bits, MSB first. A mismatch sets `crc_err_o` at end of response.
- R7: When `crc_dis_i` is high at arm, `crc_err_o` stays 0 for that response whatever CRC field arrives.
- R8: `fmt_err_o` is set at end of response if stream bit 1 (the transmission bit) is not 0, or if the last bit (the end bit) is not 1.
- R9: `eor_o` stays high until `eor_clr_i` or the next arm. An arm also clears `crc_err_o` and `fmt_err_o`. After reset, all flags and `busy_o` are 0 and the store reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one line bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_done_i | input | 1 | Pulse marking the end of the command |
| resp_en_i | input | 1 | A response is expected |
| resp_long_i | input | 1 | 1 = 136-bit response, 0 = 48-bit response |
| crc_dis_i | input | 1 | Skip the CRC7 check |
| cmd_line_i | input | 1 | Serial command line sample |
| eor_clr_i | input | 1 | Clears the end-of-response flag |
| rd_en_i | input | 1 | Advance the read pointer |
| rptr_rst_i | input | 1 | Hold the read pointer at zero |
| rd_data_o | output | 8 | Byte at the read pointer |
| busy_o | output | 1 | Armed or receiving |
| eor_o | output | 1 | End of response / interrupt request |
| crc_err_o | output | 1 | CRC7 mismatch status |
| fmt_err_o | output | 1 | Framing error status |

## Verification
The bench builds the block with its default sizes: a 48-bit short response, a 136-bit long response and 17 store entries. With these sizes, a long response fills every entry, so the last byte index and the pointer wrap are both reached. The short and long CRC windows, the framing checks, the CRC bypass and the non-armed case are each exercised with frames computed in the bench.

// File: rtl/cmd_resp_pkg.sv
package cmd_resp_pkg;
  localparam int unsigned CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RECV} rx_state_e;
endpackage

// File: rtl/crc7_acc.sv
module crc7_acc
  import cmd_resp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic zero_o
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb = crc_q[CRC_W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  // message followed by its CRC leaves a zero remainder
  assign zero_o = (crc_q == '0);
endmodule

// File: rtl/resp_fifo.sv
module resp_fifo #(
  parameter int unsigned DEPTH = 17,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_en_i,
  input  logic          rptr_rst_i,
  output logic [7:0]    rd_data_o,
  output logic [IW-1:0] rptr_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [IW-1:0] rptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))    mem_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rptr_q <= '0;
    else if (rptr_rst_i) rptr_q <= '0;
    else if (rd_en_i)    rptr_q <= (rptr_q == IW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
  end

  assign rd_data_o = mem_q[rptr_q];
  assign rptr_o    = rptr_q;
endmodule

// File: rtl/resp_ctrl.sv
module resp_ctrl
  import cmd_resp_pkg::*;
#(
  parameter int unsigned SHORT_BITS = 48,
  parameter int unsigned LONG_BITS  = 136,
  parameter int unsigned SHORT_CRC_FROM = 0,
  parameter int unsigned LONG_CRC_FROM  = 8,
  localparam int unsigned CW = $clog2(LONG_BITS + 1),
  localparam int unsigned IW = $clog2(LONG_BITS / 8)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_done_i,
  input  logic          resp_en_i,
  input  logic          resp_long_i,
  input  logic          crc_dis_i,
  input  logic          line_i,
  input  logic          eor_clr_i,
  input  logic          crc_zero_i,
  output logic          crc_clr_o,
  output logic          crc_en_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [7:0]    wr_byte_o,
  output logic          busy_o,
  output logic          eor_o,
  output logic          crc_err_o,
  output logic          fmt_err_o,
  output logic          cfg_crc_dis_o
);
  rx_state_e     state_q;
  logic [CW-1:0] cnt_q, pos, last_pos, crc_from;
  logic [6:0]    sh_q;
  logic          long_q, dis_q, tbit_q, eor_q, crc_err_q, fmt_err_q;
  logic          arm, bit_vld, at_last;

  assign arm      = (state_q == ST_IDLE) && cmd_done_i && resp_en_i;
  assign bit_vld  = ((state_q == ST_WAIT) && !line_i) || (state_q == ST_RECV);
  assign pos      = (state_q == ST_WAIT) ? '0 : cnt_q;
  assign last_pos = long_q ? CW'(LONG_BITS - 1) : CW'(SHORT_BITS - 1);
  assign crc_from = long_q ? CW'(LONG_CRC_FROM) : CW'(SHORT_CRC_FROM);
  assign at_last  = bit_vld && (pos == last_pos);

  assign crc_clr_o = arm;
  assign crc_en_o  = bit_vld && (pos >= crc_from) && (pos < last_pos);
  assign wr_en_o   = bit_vld && (pos[2:0] == 3'd7);
  assign wr_idx_o  = IW'(pos >> 3);
  assign wr_byte_o = {sh_q, line_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      long_q  <= 1'b0;
      dis_q   <= 1'b0;
      tbit_q  <= 1'b0;
    end else begin
      if (arm) begin
        state_q <= ST_WAIT;
        long_q  <= resp_long_i;
        dis_q   <= crc_dis_i;
      end else if (bit_vld) begin
        sh_q  <= {sh_q[5:0], line_i};
        cnt_q <= pos + 1'b1;
        if (pos == CW'(1)) tbit_q <= line_i;
        state_q <= at_last ? ST_IDLE : ST_RECV;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eor_q     <= 1'b0;
      crc_err_q <= 1'b0;
      fmt_err_q <= 1'b0;
    end else if (arm) begin
      eor_q     <= 1'b0;
      crc_err_q <= 1'b0;
      fmt_err_q <= 1'b0;
    end else if (at_last) begin
      eor_q     <= 1'b1;
      crc_err_q <= !dis_q && !crc_zero_i;
      fmt_err_q <= tbit_q || !line_i;
    end else if (eor_clr_i) begin
      eor_q <= 1'b0;
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign eor_o         = eor_q;
  assign crc_err_o     = crc_err_q;
  assign fmt_err_o     = fmt_err_q;
  assign cfg_crc_dis_o = dis_q;
endmodule

// File: rtl/cmd_resp_rx.sv
module cmd_resp_rx #(
  parameter int unsigned SHORT_BITS = 48,
  parameter int unsigned LONG_BITS  = 136,
  localparam int unsigned DEPTH = LONG_BITS / 8,
  localparam int unsigned IW    = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_done_i,
  input  logic       resp_en_i,
  input  logic       resp_long_i,
  input  logic       crc_dis_i,
  input  logic       cmd_line_i,
  input  logic       eor_clr_i,
  input  logic       rd_en_i,
  input  logic       rptr_rst_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic       eor_o,
  output logic       crc_err_o,
  output logic       fmt_err_o
);
  logic          crc_clr, crc_en, crc_zero, wr_en, cfg_crc_dis;
  logic [IW-1:0] wr_idx, rptr;
  logic [7:0]    wr_byte;

  resp_ctrl #(.SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)) u_ctrl (
    .clk_i, .rst_ni, .cmd_done_i, .resp_en_i, .resp_long_i, .crc_dis_i,
    .line_i(cmd_line_i), .eor_clr_i, .crc_zero_i(crc_zero),
    .crc_clr_o(crc_clr), .crc_en_o(crc_en), .wr_en_o(wr_en),
    .wr_idx_o(wr_idx), .wr_byte_o(wr_byte), .busy_o, .eor_o,
    .crc_err_o, .fmt_err_o, .cfg_crc_dis_o(cfg_crc_dis)
  );

  crc7_acc u_crc (
    .clk_i, .rst_ni, .clr_i(crc_clr), .en_i(crc_en), .bit_i(cmd_line_i),
    .zero_o(crc_zero)
  );

  resp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_byte),
    .rd_en_i, .rptr_rst_i, .rd_data_o, .rptr_o(rptr)
  );
endmodule

// File: rtl/cmd_resp_rx_checker.sv
module cmd_resp_rx_checker #(
  parameter int unsigned IW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_done_i,
  input logic          resp_en_i,
  input logic          rptr_rst_i,
  input logic          busy_o,
  input logic          eor_o,
  input logic          crc_err_o,
  input logic          cfg_crc_dis,
  input logic [IW-1:0] rptr
);
  assert_busy_after_arm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_done_i && resp_en_i) |=> busy_o);

  assert_no_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_done_i && !resp_en_i) |=> !busy_o);

  assert_eor_at_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eor_o) |-> $fell(busy_o));

  assert_rptr_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr_rst_i |=> (rptr == '0));

  assert_crc_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(eor_o) && cfg_crc_dis) |-> !crc_err_o);

  assert_eor_low_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !eor_o);
endmodule

bind cmd_resp_rx cmd_resp_rx_checker #(.IW(IW)) u_chk (
  .clk_i, .rst_ni, .cmd_done_i, .resp_en_i, .rptr_rst_i, .busy_o, .eor_o,
  .crc_err_o, .cfg_crc_dis, .rptr
);

// File: tb/cmd_resp_rx_bench.sv
module cmd_resp_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_done = 0, resp_en = 0, resp_long = 0, crc_dis = 0, line = 1;
  logic eor_clr = 0, rd_en = 0, rptr_rst = 0;
  logic [7:0] rd_data;
  logic busy, eor, crc_err, fmt_err;
  int checks = 0, fails = 0;
  logic [135:0] frm;  // frm[i] = stream bit i

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_resp_rx u_cmd_resp_rx (
    .clk_i(clk), .rst_ni(rst_n), .cmd_done_i(cmd_done), .resp_en_i(resp_en),
    .resp_long_i(resp_long), .crc_dis_i(crc_dis), .cmd_line_i(line),
    .eor_clr_i(eor_clr), .rd_en_i(rd_en), .rptr_rst_i(rptr_rst),
    .rd_data_o(rd_data), .busy_o(busy), .eor_o(eor), .crc_err_o(crc_err),
    .fmt_err_o(fmt_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc_of(input int from, input int to);
    logic [6:0] c = '0;
    for (int i = from; i <= to; i++) begin
      logic fb = c[6] ^ frm[i];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  task automatic build_short(input logic [5:0] idx, input logic [31:0] arg);
    frm = '1;
    frm[0] = 0; frm[1] = 0;
    for (int j = 0; j < 6; j++)  frm[2+j] = idx[5-j];
    for (int j = 0; j < 32; j++) frm[8+j] = arg[31-j];
    begin
      logic [6:0] c = crc_of(0, 39);
      for (int j = 0; j < 7; j++) frm[40+j] = c[6-j];
    end
    frm[47] = 1;
  endtask

  task automatic build_long(input logic [7:0] seed);
    frm = '1;
    frm[0] = 0; frm[1] = 0;
    for (int j = 8; j < 128; j++) frm[j] = ^(8'(j) ^ seed) ^ j[1];
    begin
      logic [6:0] c = crc_of(8, 127);
      for (int j = 0; j < 7; j++) frm[128+j] = c[6-j];
    end
    frm[135] = 1;
  endtask

  function automatic logic [7:0] exp_byte(input int k);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[7-j] = frm[8*k+j];
    return b;
  endfunction

  task automatic arm(input logic en, input logic lng, input logic dis);
    @(negedge clk);
    cmd_done = 1; resp_en = en; resp_long = lng; crc_dis = dis; line = 1;
    @(negedge clk);
    cmd_done = 0;
    repeat (3) @(negedge clk);  // idle ones before start bit
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      line = frm[i];
      @(negedge clk);
    end
    line = 1;
  endtask

  task automatic read_back(input string req, input int n);
    rptr_rst = 1; @(negedge clk); rptr_rst = 0;
    for (int k = 0; k < n; k++) begin
      chk(req, rd_data, exp_byte(k));
      rd_en = 1; @(negedge clk);
    end
    rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R9 reset busy", {7'd0, busy}, 8'd0);
    chk("R9 reset eor", {7'd0, eor}, 8'd0);
    chk("R9 reset crc", {7'd0, crc_err}, 8'd0);
    chk("R9 reset fmt", {7'd0, fmt_err}, 8'd0);
    chk("R9 reset data", rd_data, 8'd0);
  endtask

  task automatic t_short_good;
    build_short(6'h11, 32'hA5C3_0F96);
    arm(1, 0, 0);
    chk("R1 busy while waiting", {7'd0, busy}, 8'd1);
    send(48);
    chk("R3 short eor", {7'd0, eor}, 8'd1);
    chk("R3 short busy low", {7'd0, busy}, 8'd0);
    chk("R6 short crc ok", {7'd0, crc_err}, 8'd0);
    chk("R8 short fmt ok", {7'd0, fmt_err}, 8'd0);
    read_back("R4 short bytes", 6);
  endtask

  task automatic t_short_bad_crc;
    build_short(6'h2A, 32'h1234_5678);
    frm[44] = ~frm[44];
    arm(1, 0, 0);
    chk("R9 arm clears eor", {7'd0, eor}, 8'd0);
    send(48);
    chk("R6 short crc error", {7'd0, crc_err}, 8'd1);
    chk("R8 fmt ok on crc error", {7'd0, fmt_err}, 8'd0);
    arm(1, 0, 1);
    chk("R9 arm clears crc", {7'd0, crc_err}, 8'd0);
    send(48);
    chk("R7 crc bypass", {7'd0, crc_err}, 8'd0);
    chk("R7 eor with bypass", {7'd0, eor}, 8'd1);
  endtask

  task automatic t_format;
    build_short(6'h05, 32'hDEAD_BEEF);
    frm[1] = 1;
    arm(1, 0, 1);
    send(48);
    chk("R8 transmission bit", {7'd0, fmt_err}, 8'd1);
    build_short(6'h05, 32'hDEAD_BEEF);
    frm[47] = 0;
    arm(1, 0, 0);
    send(48);
    chk("R8 end bit", {7'd0, fmt_err}, 8'd1);
    chk("R6 crc ok with bad end", {7'd0, crc_err}, 8'd0);
  endtask

  task automatic t_long;
    build_long(8'h3C);
    arm(1, 1, 0);
    send(48);
    chk("R3 long not done at 48", {7'd0, eor}, 8'd0);
    chk("R3 long busy at 48", {7'd0, busy}, 8'd1);
    for (int i = 48; i < 136; i++) begin line = frm[i]; @(negedge clk); end
    line = 1;
    chk("R3 long eor", {7'd0, eor}, 8'd1);
    chk("R6 long crc ok", {7'd0, crc_err}, 8'd0);
    chk("R8 long fmt ok", {7'd0, fmt_err}, 8'd0);
    read_back("R4 long bytes", 17);
    chk("R4 pointer wrap", rd_data, exp_byte(0));
    build_long(8'hC1);
    frm[100] = ~frm[100];
    arm(1, 1, 0);
    send(136);
    chk("R6 long crc error", {7'd0, crc_err}, 8'd1);
  endtask

  task automatic t_rptr;
    build_long(8'h77);
    arm(1, 1, 1);
    send(136);
    rptr_rst = 1; @(negedge clk); rptr_rst = 0;
    rd_en = 1; repeat (3) @(negedge clk); rd_en = 0;
    chk("R4 third byte", rd_data, exp_byte(3));
    rptr_rst = 1; @(negedge clk); rptr_rst = 0;
    chk("R5 rewind", rd_data, exp_byte(0));
  endtask

  task automatic t_no_resp;
    logic [7:0] keep;
    keep = exp_byte(0);
    @(negedge clk); eor_clr = 1; @(negedge clk); eor_clr = 0;
    chk("R9 eor cleared", {7'd0, eor}, 8'd0);
    build_short(6'h3F, 32'h0000_0001);
    arm(0, 0, 0);
    chk("R2 not busy", {7'd0, busy}, 8'd0);
    send(48);
    chk("R2 no eor", {7'd0, eor}, 8'd0);
    rptr_rst = 1; @(negedge clk); rptr_rst = 0;
    chk("R2 store untouched", rd_data, keep);
  endtask

  initial begin
    #(CLK_PERIOD*3);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_short_good();
    t_short_bad_crc();
    t_format();
    t_long();
    t_rptr();
    t_no_resp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule